// File: doc/BRIEF.md
# Multi-channel register-programmed PWM bank

This block holds a small bank of independent pulse-width-modulated outputs that a host sets up through a byte-wide register port (address, write data, write strobe, combinational read data). Each channel keeps a 4-bit frequency code and a 10-bit duty field. A shared control register carries one enable bit per channel. An enabled channel divides the system clock into quanta of (32 − code) cycles. It runs periods of exactly 1024 quanta and holds its output high for the first (duty field + 1) quanta of each period.

Duty and frequency changes made while a channel runs are held back until the running period ends, so the output never shows a torn period. Enabling a channel restarts its counters, and its output rises at the start of the first quantum. A constant-low output comes only from clearing the enable bit, because the shortest programmable high time is one quantum.

Top module: `pwmbank_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared: after reset all addresses read 0 and every `pwm_out` bit is 0.
- R2: Channel n owns two registers. The one at `BASE_ADDR + 2n` holds bits [7:0] of the duty field. The one at `BASE_ADDR + 2n + 1` holds duty bits [9:8] in bits [1:0] and the frequency code in bits [7:4], with bits [3:2] reading 0. Both read back what was last written.
- R3: The control register at `CTRL_ADDR` holds the enable for channel n in bit n. Bits at and above `NUM_CH` read 0 and ignore writes.
- R4: Every other address reads 0, and writes to it change no register.
- R5: A quantum lasts (32 − code) clock cycles, and a period lasts 1024 quanta.
- R6: In each period the output is high for the first (duty field + 1) quanta and low for the rest. A field of 1023 gives a constant-high output; a field of 0 gives one quantum high.
- R7: When a channel's enable bit goes from 0 to 1, its counters restart. Its output is high in the cycle that follows the second rising clock edge after the write cycle's edge, that is, starting one cycle after the control register updates.
- R8: A channel whose enable bit is 0 drives its output low. From the second clock edge after the write that clears the bit, the output is low.
- R9: Duty and frequency writes made while a channel runs take effect at the next period boundary; the running period completes with the old settings.
- R10: Channels run independently: enabling, disabling or reprogramming one channel does not disturb the output of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic samples on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register address for both reads and writes |
| reg_wdata | input | 8 | Write data byte |
| reg_we | input | 1 | Write strobe; the addressed register takes `reg_wdata` at the clock edge |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The hardest situation to reach is a reconfiguration that lands in the middle of a running period and has to show up exactly at the following boundary, with both a new duty and a new quantum length. The stimulus enables one channel at the fastest code and writes the two registers about five thousand cycles into the first period. It then compares the output cycle by cycle across the rest of the old period and the whole of the new, longer one. The extreme duty fields, 0 and 1023, and the longest quantum are exercised in the same multi-channel window, alongside random settings on the other channels.

// File: rtl/pwmbank_pkg.sv
// Shared constants and types for the PWM bank.
// Assumes the duty field is 10 bits and the frequency code 4 bits; the quantum
// divisor is DIV_TOP minus the code.
package pwmbank_pkg;
    localparam int DUTY_W  = 10;
    localparam int FREQ_W  = 4;
    localparam int DIV_TOP = 32;
    localparam int PRE_W   = $clog2(DIV_TOP);
    localparam int DATA_W  = 8;

    // Configuration of one channel as held in the register file.
    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic [DUTY_W-1:0] duty_m1;
    } pwm_cfg_t;
endpackage

// File: rtl/pwmbank_regs.sv
// Register file of the PWM bank: a pair of configuration registers per channel
// and one control register with an enable bit per channel.
// Assumes the channel pairs and CTRL_ADDR do not overlap. Reads are combinational;
// unmapped addresses read zero and ignore writes.
module pwmbank_regs
    import pwmbank_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 0,
    parameter int CTRL_ADDR = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       we,
    output logic [DATA_W-1:0]          rdata,
    output pwm_cfg_t [NUM_CH-1:0]      cfg_o,
    output logic [NUM_CH-1:0]          en_o
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic [NUM_CH-1:0] en_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_cfg
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE_ADDR + 2 * i);
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_ADDR + 2 * i + 1);
        pwm_cfg_t cfg_r;

        // Capture writes to this channel's low-duty and high/frequency registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_r <= '0;
            end else if (we) begin
                if (addr == LO_A) cfg_r.duty_m1[7:0] <= wdata;
                if (addr == HI_A) begin
                    cfg_r.duty_m1[DUTY_W-1:8] <= wdata[DUTY_W-9:0];
                    cfg_r.freq                <= wdata[7:4];
                end
            end
        end

        assign cfg_o[i] = cfg_r;
    end

    // Capture writes to the shared enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                    en_q <= '0;
        else if (we && addr == CTRL_A) en_q <= wdata[NUM_CH-1:0];
    end

    assign en_o = en_q;

    // Select the read data for the current address; anything unmapped reads zero.
    always_comb begin
        rdata = '0;
        if (addr == CTRL_A) rdata = DATA_W'(en_q);
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(BASE_ADDR + 2 * i))
                rdata = cfg_o[i].duty_m1[7:0];
            if (addr == ADDR_W'(BASE_ADDR + 2 * i + 1))
                rdata = {cfg_o[i].freq, 2'b00, cfg_o[i].duty_m1[DUTY_W-1:8]};
        end
    end
endmodule

// File: rtl/pwmbank_prescale.sv
// Quantum prescaler for one channel: counts clock cycles and pulses `tick`
// on the last cycle of every quantum of (DIV_TOP - code) cycles.
// Assumes `code` is stable within a quantum (the channel shadows it).
module pwmbank_prescale
    import pwmbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic [FREQ_W-1:0] code,
    output logic              tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] term;

    assign term = PRE_W'(DIV_TOP - 1) - PRE_W'(code);
    assign tick = run && (cnt_q == term);

    // Step through one quantum, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) cnt_q <= '0;
        else if (tick)                 cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwmbank_chan.sv
// One PWM channel: shadows its configuration at period boundaries, counts
// quanta through a 1024-quantum period and drives its output high for the
// first (duty_m1 + 1) quanta.
// Assumes `en` comes from a register; a rising enable restarts all counters.
module pwmbank_chan
    import pwmbank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  pwm_cfg_t cfg,
    output logic     pwm_o
);
    localparam logic [DUTY_W-1:0] LAST_Q = '1;

    logic              running_q;
    logic [DUTY_W-1:0] qcnt_q;
    pwm_cfg_t          shadow_q;
    logic              start;
    logic              tick;

    assign start = en && !running_q;

    pwmbank_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (running_q),
        .code    (shadow_q.freq),
        .tick    (tick)
    );

    // Track enable, count quanta and reload the shadow at each period wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            qcnt_q    <= '0;
            shadow_q  <= '0;
        end else begin
            running_q <= en;
            if (start) begin
                qcnt_q   <= '0;
                shadow_q <= cfg;
            end else if (running_q && tick) begin
                qcnt_q <= qcnt_q + 1'b1;
                if (qcnt_q == LAST_Q) shadow_q <= cfg;
            end
        end
    end

    assign pwm_o = running_q && (qcnt_q <= shadow_q.duty_m1);
endmodule

// File: rtl/pwmbank_top.sv
// Top of the PWM bank: register file plus NUM_CH independent channels.
// Assumes 1 <= NUM_CH <= 8 so the enables fit one byte.
module pwmbank_top
    import pwmbank_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 0,
    parameter int CTRL_ADDR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_we,
    output logic [7:0]        reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    pwm_cfg_t [NUM_CH-1:0] cfg;
    logic     [NUM_CH-1:0] ctrl_en;

    pwmbank_regs #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .we    (reg_we),
        .rdata (reg_rdata),
        .cfg_o (cfg),
        .en_o  (ctrl_en)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwmbank_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ctrl_en[i]),
            .cfg   (cfg[i]),
            .pwm_o (pwm_out[i])
        );
    end
endmodule

// File: rtl/pwmbank_checker.sv
// Temporal checks on the PWM bank, bound to the top module.
// Assumes it sees the register enables and the channel outputs of the top.
module pwmbank_checker #(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 8,
    parameter int CTRL_ADDR = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              reg_we,
    input logic [NUM_CH-1:0] en_q,
    input logic [NUM_CH-1:0] pwm_out
);
    // R1: a reset edge leaves every output low.
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0));

    // R3: a control write lands in the enable bits.
    assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(CTRL_ADDR)) |=> (en_q == $past(reg_wdata[NUM_CH-1:0])));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R7: a fresh enable starts the period with the output high.
        assert_start_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en_q[i]) |=> pwm_out[i]);

        // R8: a cleared enable forces the output low at the next edge.
        assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[i] |=> !pwm_out[i]);

        // R8: the output never rises unless the channel was enabled.
        assert_rise_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_out[i]) |-> $past(en_q[i]));
    end
endmodule

bind pwmbank_top pwmbank_checker #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .en_q      (ctrl_en),
    .pwm_out   (pwm_out)
);

// File: tb/pwmbank_top_bench.sv
module pwmbank_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;
    localparam int ADDR_W     = 8;
    localparam int CTRL       = 16;
    localparam int NADDR      = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic              reg_we = 1'b0;
    logic [7:0]        reg_rdata;
    logic [NUM_CH-1:0] pwm_out;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic [7:0] model [NADDR];
    int  fr [NUM_CH];
    int  dm [NUM_CH];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwmbank_top #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (0),
        .CTRL_ADDR (CTRL)
    ) u_pwmbank_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    // Expected output level k cycles after the first high cycle.
    function automatic bit exp_level(int k, int code, int duty_m1);
        int dv;
        dv = 32 - code;
        return (k % (1024 * dv)) < ((duty_m1 + 1) * dv);
    endfunction

    // Bits of each address that hold state.
    function automatic logic [7:0] rb_mask(int a);
        if (a < 2 * NUM_CH) return (a % 2 == 0) ? 8'hFF : 8'hF3;
        if (a == CTRL) return 8'((1 << NUM_CH) - 1);
        return 8'h00;
    endfunction

    function automatic string addr_req(int a);
        if (a < 2 * NUM_CH) return "R2";
        if (a == CTRL) return "R3";
        return "R4";
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_addr  = ADDR_W'(a);
        reg_wdata = 8'(d);
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(int a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic program_ch(int ch, int code, int duty_m1);
        wr(2 * ch, duty_m1 & 255);
        wr(2 * ch + 1, (code << 4) | (duty_m1 >> 8));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int a;
        int mism;
        int first_k;
        bit first_act;
        void'($urandom(32'd4711));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of outputs and registers.
        check(pwm_out == '0, "R1", "outputs after reset", int'(pwm_out), 0);
        for (int i = 0; i < NADDR; i++) begin
            rd(i, d);
            check(d == 8'h00, "R1", $sformatf("addr %0d after reset", i), int'(d), 0);
            model[i] = 8'h00;
        end

        // R2 R3 R4: random writes across the whole address range, then full readback.
        for (int n = 0; n < 40; n++) begin
            a = int'($urandom % NADDR);
            d = 8'($urandom);
            wr(a, int'(d));
            model[a] = d & rb_mask(a);
        end
        for (int i = 0; i < NADDR; i++) begin
            rd(i, d);
            check(d == model[i], addr_req(i), $sformatf("readback addr %0d", i), int'(d), int'(model[i]));
        end

        // R4: directed write to an unused address leaves everything untouched.
        wr(31, 8'hFF);
        rd(31, d);
        check(d == 8'h00, "R4", "unused addr 31", int'(d), 0);
        rd(0, d);
        check(d == model[0], "R4", "addr 0 after unused write", int'(d), int'(model[0]));

        // R3: upper control bits read zero.
        wr(CTRL, 8'hFF);
        rd(CTRL, d);
        check(d == 8'h0F, "R3", "ctrl upper bits", int'(d), 15);
        wr(CTRL, 0);
        repeat (2) @(negedge clk);
        // R8: all channels low once disabled.
        check(pwm_out == '0, "R8", "outputs after disable all", int'(pwm_out), 0);

        // R5 R6 R7: four channels with extreme and random settings, checked every cycle.
        fr[0] = 0;  dm[0] = 0;
        fr[1] = 15; dm[1] = 1023;
        fr[2] = int'($urandom % 16); dm[2] = int'($urandom % 1024);
        fr[3] = int'($urandom % 16); dm[3] = int'($urandom % 1024);
        for (int c = 0; c < NUM_CH; c++) program_ch(c, fr[c], dm[c]);
        wr(CTRL, 8'h0F);
        @(negedge clk);
        check(pwm_out == 4'hF, "R7", "first cycle after enable", int'(pwm_out), 15);
        begin
            int mm [NUM_CH];
            int fk [NUM_CH];
            int fa [NUM_CH];
            for (int c = 0; c < NUM_CH; c++) begin mm[c] = 0; fk[c] = 0; fa[c] = 0; end
            for (int k = 0; k < 34000; k++) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (pwm_out[c] !== exp_level(k, fr[c], dm[c])) begin
                        if (mm[c] == 0) begin fk[c] = k; fa[c] = int'(pwm_out[c]); end
                        mm[c]++;
                    end
                end
                @(negedge clk);
            end
            for (int c = 0; c < NUM_CH; c++)
                check(mm[c] == 0, "R5 R6",
                      $sformatf("ch%0d code %0d duty %0d first miss cycle %0d", c, fr[c], dm[c], fk[c]),
                      fa[c], 1 - fa[c]);
        end

        // R8 R10: disable channels 0 and 2, channel 1 stays constant high.
        wr(CTRL, 8'h0A);
        @(negedge clk);
        check(pwm_out[0] == 1'b0, "R8", "ch0 low after disable", int'(pwm_out[0]), 0);
        check(pwm_out[2] == 1'b0, "R8", "ch2 low after disable", int'(pwm_out[2]), 0);
        check(pwm_out[1] == 1'b1, "R10", "ch1 undisturbed", int'(pwm_out[1]), 1);
        wr(CTRL, 0);
        repeat (2) @(negedge clk);

        // R9: mid-period rewrite of duty and code takes effect at the boundary.
        program_ch(0, 15, 100);
        wr(CTRL, 8'h01);
        @(negedge clk);
        mism = 0; first_k = 0; first_act = 1'b0;
        for (int k = 0; k < 36000; k++) begin
            bit e;
            if (k == 5000) begin
                reg_addr = 8'd0; reg_wdata = 8'd88; reg_we = 1'b1;
            end else if (k == 5001) begin
                reg_addr = 8'd1; reg_wdata = 8'hE2;
            end else if (k == 5002) begin
                reg_we = 1'b0;
            end
            e = (k < 17408) ? exp_level(k, 15, 100) : exp_level(k - 17408, 14, 600);
            if (pwm_out[0] !== e) begin
                if (mism == 0) begin first_k = k; first_act = pwm_out[0]; end
                mism++;
            end
            if (pwm_out[3:1] !== 3'b000) mism++;
            @(negedge clk);
        end
        check(mism == 0, "R9", $sformatf("reconfigure at boundary, first miss cycle %0d", first_k),
              int'(first_act), 1 - int'(first_act));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule